// File: doc/BRIEF.md
# Two-Wire Register Port Slave

This block is a serial two-wire (I2C) target that gives a host access to a small bank of 8-bit registers. It oversamples the clock and data lines on the system clock, cleans them with a synchronizer and a majority-free stability filter, and detects START, repeated START and STOP. It acknowledges its own 7-bit device address (0x30 by default) and pulls the data line low through an open-drain drive output for acknowledges and read data.

The registers themselves live in a separate register file. The slave hands each received data byte to that file as a one-cycle write strobe with an address and data. It asks for each byte it is about to transmit with a one-cycle read strobe and address, which the file may also use to clear status bits on read. An internal pointer names the next location to access. It auto-increments after every data byte and wraps from the top location back to zero, so reads and writes both continue from where the last access stopped.

Top module: `i2c_regport_slave`

## Requirements
- R1: A level on either line is accepted only after it has held for FILT_LEN (3) consecutive synchronized samples; a 2-cycle pulse on SCL while it is low, or on SDA while SCL is high, has no effect on a transfer.
- R2: The first byte after a START or repeated START is the address byte, sent MSB first: bits 7..1 are the device address and bit 0 is R/W (0 = write, 1 = read), so 0x60 writes and 0x61 reads at address 0x30. A match is acknowledged by driving SDA low for the ninth clock.
- R3: A non-matching address byte is not acknowledged, and every following byte is ignored with no strobe and no pointer change until the next START or STOP.
- R4: In a write, the byte after the address byte loads the pointer from its low ADDR_W bits, upper bits ignored. Each further byte is acknowledged and produces one single-cycle wr_stb with wr_addr equal to the pointer and wr_data equal to the byte; the pointer then increments.
- R5: The pointer wraps from the top location (7) to 0 for both writes and reads.
- R6: A read that follows the address byte directly starts at the pointer, which is the location after the last accessed one (0 after reset). Each byte is requested with a single-cycle rd_stb carrying rd_addr, and the pointer then increments.
- R7: A write of a register address followed by a repeated START and a read address byte returns data starting at that register address.
- R8: Read data is sent MSB first. SDA drive changes only while SCL is low. The register file must present rd_data one cycle after the edge where it samples rd_stb high, as a registered read does.
- R9: A master NACK after a read byte releases SDA and ends the read with no further rd_stb. A master ACK requests the next byte.
- R10: A START or STOP at any point releases SDA. A data byte cut short by one produces no write strobe, and a START always begins a new address byte.
- R11: After reset SDA is released, no strobe is asserted and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_drive_low_o | output | 1 | 1 pulls SDA low (open drain) |
| wr_stb_o | output | 1 | One-cycle write request to the register file |
| wr_addr_o | output | ADDR_W | Register location being written |
| wr_data_o | output | 8 | Byte being written |
| rd_stb_o | output | 1 | One-cycle read request, usable for clear-on-read |
| rd_addr_o | output | ADDR_W | Register location being read |
| rd_data_i | input | 8 | Registered read data from the register file |

## Verification
The bench sweeps every start location for both write and combined-read bursts of nine bytes, so every wrap from 7 to 0 is crossed. A pointer that saturated or missed the wrap would write or return the wrong location. Reads without a register address are checked after a reset, after a write and after a read. A design that reset the pointer on each transfer, or advanced it wrongly on the address phase, would return the wrong byte. Foreign addresses followed by data bytes, transfers cut by STOP or repeated START mid-byte, and short glitches on both lines are also driven. These catch a slave that acknowledges the wrong device, writes half-received bytes, or counts a spike as a clock edge or a bus condition.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

  localparam int BYTE_W   = 8;
  localparam int LINE_CNT = 2;
  localparam int SCL_IDX  = 0;
  localparam int SDA_IDX  = 1;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RD_WAIT,
    ST_RD_LOAD,
    ST_RD_BIT,
    ST_RD_ACK,
    ST_SKIP
  } slv_state_e;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '1;
      hist_q  <= '1;
      level_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (&hist_q)
        level_q <= 1'b1;
      else if (~|hist_q)
        level_q <= 1'b0;
    end
  end

  assign line_o = level_q;

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_lvl_i,
  input  logic sda_lvl_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o,
  output logic sda_o
);

  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      start_o <= 1'b0;
      stop_o  <= 1'b0;
      rise_o  <= 1'b0;
      fall_o  <= 1'b0;
      sda_o   <= 1'b1;
    end else begin
      scl_q   <= scl_lvl_i;
      sda_q   <= sda_lvl_i;
      start_o <= scl_q & scl_lvl_i & sda_q & ~sda_lvl_i;
      stop_o  <= scl_q & scl_lvl_i & ~sda_q & sda_lvl_i;
      rise_o  <= ~scl_q & scl_lvl_i;
      fall_o  <= scl_q & ~scl_lvl_i;
      sda_o   <= sda_lvl_i;
    end
  end

endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import i2c_regport_pkg::*;
#(
  parameter int          ADDR_W   = 3,
  parameter logic [6:0]  DEV_ADDR = 7'h30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sda_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_drive_low_o,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_stb_o,
  output logic [ADDR_W-1:0] rd_addr_o
);

  localparam int               CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [ADDR_W-1:0] PTR_ONE = ADDR_W'(1);

  slv_state_e        state_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] shift_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              is_read_q;
  logic              mack_q;
  logic              drive_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      shift_q   <= '0;
      ptr_q     <= '0;
      is_read_q <= 1'b0;
      mack_q    <= 1'b0;
      drive_q   <= 1'b0;
      wr_stb_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      rd_stb_o  <= 1'b0;
      rd_addr_o <= '0;
    end else begin
      wr_stb_o <= 1'b0;
      rd_stb_o <= 1'b0;
      if (start_i) begin
        state_q   <= ST_DEV;
        bit_cnt_q <= '0;
        drive_q   <= 1'b0;
      end else if (stop_i) begin
        state_q   <= ST_IDLE;
        bit_cnt_q <= '0;
        drive_q   <= 1'b0;
      end else begin
        case (state_q)
          ST_DEV, ST_REG, ST_WDAT: begin
            if (rise_i && bit_cnt_q != CNT_FULL) begin
              shift_q   <= {shift_q[BYTE_W-2:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (fall_i && bit_cnt_q == CNT_FULL) begin
              bit_cnt_q <= '0;
              case (state_q)
                ST_DEV: begin
                  if (shift_q[BYTE_W-1:1] == DEV_ADDR) begin
                    is_read_q <= shift_q[0];
                    drive_q   <= 1'b1;
                    state_q   <= ST_DEV_ACK;
                  end else begin
                    state_q <= ST_SKIP;
                  end
                end
                ST_REG: begin
                  ptr_q   <= shift_q[ADDR_W-1:0];
                  drive_q <= 1'b1;
                  state_q <= ST_REG_ACK;
                end
                default: begin
                  wr_stb_o  <= 1'b1;
                  wr_addr_o <= ptr_q;
                  wr_data_o <= shift_q;
                  ptr_q     <= ptr_q + PTR_ONE;
                  drive_q   <= 1'b1;
                  state_q   <= ST_WDAT_ACK;
                end
              endcase
            end
          end
          ST_DEV_ACK, ST_REG_ACK, ST_WDAT_ACK: begin
            if (fall_i) begin
              drive_q <= 1'b0;
              if (state_q == ST_DEV_ACK && is_read_q) begin
                rd_stb_o  <= 1'b1;
                rd_addr_o <= ptr_q;
                ptr_q     <= ptr_q + PTR_ONE;
                state_q   <= ST_RD_WAIT;
              end else if (state_q == ST_DEV_ACK) begin
                state_q <= ST_REG;
              end else begin
                state_q <= ST_WDAT;
              end
            end
          end
          ST_RD_WAIT: state_q <= ST_RD_LOAD;
          ST_RD_LOAD: begin
            shift_q   <= rd_data_i;
            drive_q   <= ~rd_data_i[BYTE_W-1];
            bit_cnt_q <= '0;
            state_q   <= ST_RD_BIT;
          end
          ST_RD_BIT: begin
            if (fall_i) begin
              if (bit_cnt_q == CNT_LAST) begin
                drive_q <= 1'b0;
                state_q <= ST_RD_ACK;
              end else begin
                shift_q   <= {shift_q[BYTE_W-2:0], 1'b0};
                drive_q   <= ~shift_q[BYTE_W-2];
                bit_cnt_q <= bit_cnt_q + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (rise_i) begin
              mack_q <= ~sda_i;
            end else if (fall_i) begin
              if (mack_q) begin
                rd_stb_o  <= 1'b1;
                rd_addr_o <= ptr_q;
                ptr_q     <= ptr_q + PTR_ONE;
                state_q   <= ST_RD_WAIT;
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_drive_low_o = drive_q;

endmodule

// File: rtl/i2c_regport_slave.sv
module i2c_regport_slave
  import i2c_regport_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h30,
  parameter int         ADDR_W      = 3,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_drive_low_o,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_stb_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [BYTE_W-1:0] rd_data_i
);

  logic [LINE_CNT-1:0] raw_w;
  logic [LINE_CNT-1:0] filt_w;
  logic scl_f, sda_f;
  logic ev_start, ev_stop, ev_rise, ev_fall, ev_sda;

  assign raw_w[SCL_IDX] = scl_i;
  assign raw_w[SDA_IDX] = sda_i;

  for (genvar g = 0; g < LINE_CNT; g++) begin : g_line
    i2c_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk   (clk),
      .rst   (rst),
      .line_i(raw_w[g]),
      .line_o(filt_w[g])
    );
  end

  assign scl_f = filt_w[SCL_IDX];
  assign sda_f = filt_w[SDA_IDX];

  i2c_bus_events u_events (
    .clk      (clk),
    .rst      (rst),
    .scl_lvl_i(scl_f),
    .sda_lvl_i(sda_f),
    .start_o  (ev_start),
    .stop_o   (ev_stop),
    .rise_o   (ev_rise),
    .fall_o   (ev_fall),
    .sda_o    (ev_sda)
  );

  i2c_slave_ctrl #(
    .ADDR_W  (ADDR_W),
    .DEV_ADDR(DEV_ADDR)
  ) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .start_i        (ev_start),
    .stop_i         (ev_stop),
    .rise_i         (ev_rise),
    .fall_i         (ev_fall),
    .sda_i          (ev_sda),
    .rd_data_i      (rd_data_i),
    .sda_drive_low_o(sda_drive_low_o),
    .wr_stb_o       (wr_stb_o),
    .wr_addr_o      (wr_addr_o),
    .wr_data_o      (wr_data_o),
    .rd_stb_o       (rd_stb_o),
    .rd_addr_o      (rd_addr_o)
  );

endmodule

// File: rtl/i2c_regport_slave_chk.sv
module i2c_regport_slave_chk (
  input logic clk,
  input logic rst,
  input logic scl_f,
  input logic start_ev,
  input logic stop_ev,
  input logic sda_drive_low,
  input logic wr_stb,
  input logic rd_stb
);

  p_drive_scl_low_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_drive_low) |-> !scl_f);

  p_start_release_r10: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> !sda_drive_low);

  p_stop_release_r10: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> !sda_drive_low);

  p_wr_single_r4: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  p_rd_single_r6: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> !rd_stb);

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb && rd_stb));

endmodule

bind i2c_regport_slave i2c_regport_slave_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .scl_f        (scl_f),
  .start_ev     (ev_start),
  .stop_ev      (ev_stop),
  .sda_drive_low(sda_drive_low_o),
  .wr_stb       (wr_stb_o),
  .rd_stb       (rd_stb_o)
);

// File: tb/tb_i2c_regport_slave.sv
`timescale 1ns/1ps
module tb_i2c_regport_slave;

  localparam int T = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_gl = 1'b0, sda_gl = 1'b0;
  logic glitch_on = 1'b0;
  logic drv;
  logic wr_stb, rd_stb;
  logic [2:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic bus_sda, bus_scl;

  assign bus_scl = scl_m | scl_gl;
  assign bus_sda = sda_m & ~drv & ~sda_gl;

  i2c_regport_slave dut (
    .clk(clk), .rst(rst), .scl_i(bus_scl), .sda_i(bus_sda),
    .sda_drive_low_o(drv), .wr_stb_o(wr_stb), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .rd_stb_o(rd_stb), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data)
  );

  logic [7:0] mem [8];
  logic [7:0] exp_mem [8];
  logic [2:0] wlog_a [256];
  logic [7:0] wlog_d [256];
  logic [2:0] rlog_a [256];
  int wr_cnt = 0, rd_cnt = 0;
  int n_chk = 0, n_err = 0;

  initial begin
    for (int i = 0; i < 8; i++) begin
      mem[i] = 8'hA0 + 8'(i);
      exp_mem[i] = 8'hA0 + 8'(i);
    end
    rd_data = 8'h00;
  end

  always @(posedge clk) begin
    if (!rst) begin
      if (wr_stb) begin
        mem[wr_addr] <= wr_data;
        wlog_a[wr_cnt] <= wr_addr;
        wlog_d[wr_cnt] <= wr_data;
        wr_cnt <= wr_cnt + 1;
      end
      if (rd_stb) begin
        rd_data <= mem[rd_addr];
        rlog_a[rd_cnt] <= rd_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wt(T);
    scl_m = 1'b1; wt(T);
    sda_m = 1'b0; wt(T);
    scl_m = 1'b0; wt(T);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wt(T);
    scl_m = 1'b1; wt(T);
    sda_m = 1'b1; wt(T);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b;
    wt(4);
    if (glitch_on) begin scl_gl = 1'b1; wt(2); scl_gl = 1'b0; end
    else wt(2);
    wt(T - 6);
    scl_m = 1'b1;
    wt(4);
    if (glitch_on && b) begin sda_gl = 1'b1; wt(2); sda_gl = 1'b0; end
    else wt(2);
    wt(2 * T - 6);
    scl_m = 1'b0;
    wt(T);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wt(T);
    scl_m = 1'b1; wt(T);
    b = bus_sda;  wt(T);
    scl_m = 1'b0; wt(T);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = ~b;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    put_bit(~mack);
  endtask

  // read n bytes straight after the read address byte, expecting start location a0
  task automatic rd_only(input int n, input int a0, input string tag);
    logic a;
    logic [7:0] v;
    int rb;
    rb = rd_cnt;
    bus_start;
    send_byte(8'h61, a);
    chk({tag, " R2 read address ack"}, a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, v);
      chk({tag, " data"}, v, exp_mem[(a0 + k) % 8]);
      chk({tag, " rd_addr"}, rlog_a[rb + k], (a0 + k) % 8);
    end
    chk("R9 SDA released after NACK", drv, 0);
    chk("R9 no strobe after NACK", rd_cnt - rb, n);
    bus_stop;
  endtask

  initial begin
    logic a;
    logic [7:0] v, d;
    int wb, rb;
    wt(6);
    chk("R11 reset drive", drv, 0);
    chk("R11 reset wr_stb", wr_stb, 0);
    chk("R11 reset rd_stb", rd_stb, 0);
    rst = 1'b0;
    wt(10);

    // R11 and R6: pointer starts at 0
    rd_only(1, 0, "R11 R6 read after reset");

    // R4, R5, R1: write bursts of 9 bytes from every start location
    for (int s = 0; s < 8; s++) begin
      wb = wr_cnt;
      bus_start;
      send_byte(8'h60, a);
      chk("R2 write address ack", a, 1);
      send_byte({5'(s * 3), 3'(s)}, a);
      chk("R4 register address ack", a, 1);
      for (int k = 0; k < 9; k++) begin
        d = 8'(s * 37 + k * 11) ^ 8'h5A;
        glitch_on = (s == 3 && k == 0);
        send_byte(d, a);
        glitch_on = 1'b0;
        exp_mem[(s + k) % 8] = d;
        if (s == 3 && k == 0) begin
          chk("R1 glitched byte ack", a, 1);
          chk("R1 glitched byte data", wlog_d[wb + k], d);
        end else begin
          chk("R4 data ack", a, 1);
          chk("R4 wr_data", wlog_d[wb + k], d);
        end
        chk("R5 wr_addr wrap", wlog_a[wb + k], (s + k) % 8);
      end
      bus_stop;
      chk("R4 write strobe count", wr_cnt - wb, 9);
    end

    // R7, R5, R9: combined reads from every start location
    for (int s = 0; s < 8; s++) begin
      rb = rd_cnt;
      bus_start;
      send_byte(8'h60, a);
      send_byte(8'(s), a);
      bus_start;
      send_byte(8'h61, a);
      chk("R7 read address ack after repeated START", a, 1);
      for (int k = 0; k < 9; k++) begin
        recv_byte(k < 8, v);
        chk("R7 R8 combined read data", v, exp_mem[(s + k) % 8]);
        chk("R5 rd_addr wrap", rlog_a[rb + k], (s + k) % 8);
      end
      chk("R9 SDA released after NACK", drv, 0);
      chk("R9 read strobe count", rd_cnt - rb, 9);
      bus_stop;
    end

    // R6: read continues after the last write
    bus_start;
    send_byte(8'h60, a);
    send_byte(8'h05, a);
    send_byte(8'h3C, a);
    exp_mem[5] = 8'h3C;
    bus_stop;
    rd_only(3, 6, "R6 read after write");
    rd_only(1, 1, "R6 read after read");

    // R3: foreign addresses are refused and ignored
    wb = wr_cnt;
    rb = rd_cnt;
    bus_start;
    send_byte(8'h62, a);
    chk("R3 foreign write address NACK", a, 0);
    send_byte(8'h00, a);
    chk("R3 ignored byte NACK", a, 0);
    send_byte(8'h99, a);
    bus_stop;
    bus_start;
    send_byte(8'hE1, a);
    chk("R3 foreign read address NACK", a, 0);
    bus_stop;
    chk("R3 no write strobe", wr_cnt - wb, 0);
    chk("R3 no read strobe", rd_cnt - rb, 0);
    rd_only(1, 2, "R3 pointer untouched");

    // R10: STOP inside a data byte
    wb = wr_cnt;
    bus_start;
    send_byte(8'h60, a);
    send_byte(8'h04, a);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_stop;
    chk("R10 no write on cut byte (STOP)", wr_cnt - wb, 0);
    chk("R10 SDA released after STOP", drv, 0);
    rd_only(1, 4, "R10 pointer after cut write");

    // R10: repeated START inside a data byte
    wb = wr_cnt;
    rb = rd_cnt;
    bus_start;
    send_byte(8'h60, a);
    send_byte(8'h06, a);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
    bus_start;
    send_byte(8'h61, a);
    chk("R10 address after repeated START ack", a, 1);
    recv_byte(1'b0, v);
    chk("R10 read data after cut byte", v, exp_mem[6]);
    chk("R10 rd_addr after cut byte", rlog_a[rb], 6);
    chk("R10 no write on cut byte (START)", wr_cnt - wb, 0);
    bus_stop;

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule